// File: doc/BRIEF.md
# Sequenced-Unlock Watchdog Timer

This block is a bus-mapped watchdog. While enabled, an internal counter advances once per clock. Software has to feed the watchdog before the counter reaches a programmed timeout, and it does so by writing a fixed pair of magic words to a shared command address. If the timeout is reached, the block pulses a reset-request output for one clock and then freezes. A nonzero window value sets the earliest counter value at which a feed is accepted. A feed that arrives earlier counts as a fault.

The configuration consists of the enable bit, the update-permission bit, the timeout and the window. Out of reset the configuration is open and can be written directly. The first write to the control register commits it. From then on the update-permission bit decides what happens. If the bit is clear, the configuration is frozen until reset. If it is set, software must first write a separate pair of unlock words to the command address. It then has a limited number of cycles in which to rewrite the configuration.

Any write to the command address that breaks a magic-word pair raises the reset request immediately. A feed that lands inside a closed window does the same. The request is a single-cycle pulse, intended for a chip-level reset controller that lies outside this block.

Top module: `seq_wdog`

## Requirements
- R1: After reset, the control register (byte offset 0x00) reads 0x080: the enable bit 7 is 1, and the update-permission bit 5, the unlocked bit 11 and the committed bit 10 are all 0. The timeout register (0x08) reads 0x400, the window register (0x0C) reads 0, and the reset request is low.
- R2: Until the first control-register write, writes to 0x08 and 0x0C take effect directly. A control write stores bits 7 and 5, sets the committed bit 10, and clears the counter to 0. Reads return the addressed register one cycle after the address is presented, and the counter is read at offset 0x04.
- R3: After a commit with bit 5 clear, writes to 0x00, 0x08 and 0x0C have no effect until reset, even after a correct unlock pair.
- R4: After a commit with bit 5 set, two consecutive writes of 0xC520 and then 0xD928 to 0x04 set the unlocked bit 11 and clear the committed bit 10. Configuration writes then take effect, and a control write ends the unlock. Without an unlock, configuration writes are ignored.
- R5: If no control write arrives, the unlock lapses 128 cycles after it was granted. Bit 11 clears and later configuration writes are ignored.
- R6: Two consecutive writes of 0xA602 and then 0xB480 to 0x04 clear the counter to 0.
- R7: If the write that follows a first word (0xC520 or 0xA602) at 0x04 is not the matching second word, the reset request pulses in the next cycle.
- R8: While the block is enabled with a nonzero window, a feed that completes when the counter is below the window raises the reset request. A feed at or above the window is accepted.
- R9: While the block is enabled, the counter rises by one per cycle. When the counter is at or above the timeout, the reset request pulses for exactly one cycle and the counter holds until reset. A feed that completes on that same edge does not prevent the request.
- R10: Writing 0x120 to the control register disables the block and keeps bit 5 set (reads 0x420). While disabled, the counter does not advance and no timeout occurs.
- R11: At 0x04, a write that is neither a first word nor the completion of a pending pair has no effect. A write to any other offset between the two words of a pair cancels the pair, and the lone second word that follows is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the offset of the previous cycle |
| wdog_rst_req | output | 1 | One-cycle reset request |

## Verification
Two functions can land on the same clock edge: the completion of a feed and the counter reaching the timeout. The bench programs a short timeout and commits it, which zeroes the counter. It then places the second feed word on the edge just before the counter reaches the timeout, and in a separate run on the edge where it does. In the first case the counter must read 0 and no request may appear. In the second case exactly one request must appear and the counter must stay at the timeout value.

// File: rtl/seq_wdog_pkg.sv
package seq_wdog_pkg;

  // register byte offsets
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_TOV  = 4'h8;
  localparam logic [3:0] OFS_WIN  = 4'hC;

  // magic words
  localparam logic [31:0] KEY_UNLK_A = 32'h0000_C520;
  localparam logic [31:0] KEY_UNLK_B = 32'h0000_D928;
  localparam logic [31:0] KEY_FEED_A = 32'h0000_A602;
  localparam logic [31:0] KEY_FEED_B = 32'h0000_B480;

  // control register bit positions
  localparam int BIT_EN  = 7;
  localparam int BIT_UPD = 5;
  localparam int BIT_CMT = 10;
  localparam int BIT_ULK = 11;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_UNLK = 2'd1,
    PEND_FEED = 2'd2
  } pend_e;

endpackage

// File: rtl/seq_wdog_cmd.sv
module seq_wdog_cmd
  import seq_wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic              other_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlock_ok,
  output logic              feed_ok,
  output logic              seq_fault
);

  pend_e pend_q;

  logic is_ua, is_ub, is_fa, is_fb;
  assign is_ua = (wdata == DATA_W'(KEY_UNLK_A));
  assign is_ub = (wdata == DATA_W'(KEY_UNLK_B));
  assign is_fa = (wdata == DATA_W'(KEY_FEED_A));
  assign is_fb = (wdata == DATA_W'(KEY_FEED_B));

  always_comb begin
    unlock_ok = 1'b0;
    feed_ok   = 1'b0;
    seq_fault = 1'b0;
    if (cmd_we) begin
      unique case (pend_q)
        PEND_UNLK: begin
          unlock_ok = is_ub;
          seq_fault = !is_ub;
        end
        PEND_FEED: begin
          feed_ok   = is_fb;
          seq_fault = !is_fb;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= PEND_NONE;
    end else if (other_we) begin
      pend_q <= PEND_NONE;
    end else if (cmd_we) begin
      if (pend_q != PEND_NONE) pend_q <= PEND_NONE;
      else if (is_ua)          pend_q <= PEND_UNLK;
      else if (is_fa)          pend_q <= PEND_FEED;
      else                     pend_q <= PEND_NONE;
    end
  end

  // R7
  // once a pair completes or breaks, the next command write starts fresh
  pair_close_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && pend_q != PEND_NONE) |=> (pend_q == PEND_NONE));

endmodule

// File: rtl/seq_wdog_cfg.sv
module seq_wdog_cfg #(
  parameter int CNT_W      = 16,
  parameter int UNLOCK_WIN = 128,
  parameter int TOV_RST    = 'h400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             tov_we,
  input  logic             win_we,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             wr_en_bit,
  input  logic             wr_upd_bit,
  input  logic             unlock_ok,
  output logic             en,
  output logic             upd,
  output logic             unlocked,
  output logic             cmt_flag,
  output logic [CNT_W-1:0] tov,
  output logic [CNT_W-1:0] win,
  output logic             commit
);

  localparam int UW = $clog2(UNLOCK_WIN) + 1;

  logic          ever_q;
  logic [UW-1:0] ucnt_q;
  logic          writable;
  logic          grant;

  assign writable = !ever_q || unlocked;
  assign grant    = unlock_ok && ever_q && upd;
  assign commit   = ctrl_we && writable;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b1;
      upd      <= 1'b0;
      ever_q   <= 1'b0;
      cmt_flag <= 1'b0;
      unlocked <= 1'b0;
      ucnt_q   <= '0;
      tov      <= CNT_W'(TOV_RST);
      win      <= '0;
    end else begin
      if (tov_we && writable) tov <= wr_val;
      if (win_we && writable) win <= wr_val;
      if (commit) begin
        en       <= wr_en_bit;
        upd      <= wr_upd_bit;
        ever_q   <= 1'b1;
        cmt_flag <= 1'b1;
        unlocked <= 1'b0;
      end else if (grant) begin
        unlocked <= 1'b1;
        cmt_flag <= 1'b0;
        ucnt_q   <= '0;
      end else if (unlocked) begin
        if (ucnt_q == UW'(UNLOCK_WIN - 1)) unlocked <= 1'b0;
        else                               ucnt_q   <= ucnt_q + 1'b1;
      end
    end
  end

  // R3
  locked_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (ever_q && !upd) |=> ($stable(tov) && $stable(win) && $stable(en)));

  // R5
  unlock_span_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> (ucnt_q < UW'(UNLOCK_WIN)));

  // R4
  grant_sets_chk: assert property (@(posedge clk) disable iff (rst)
    grant |=> (unlocked && !cmt_flag));

endmodule

// File: rtl/seq_wdog_cnt.sv
module seq_wdog_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] tov,
  input  logic [CNT_W-1:0] win,
  input  logic             feed_ok,
  input  logic             commit,
  input  logic             seq_fault,
  output logic [CNT_W-1:0] cnt,
  output logic             tripped,
  output logic             rst_req
);

  logic tmo_hit, win_fault, fault_now, clr;

  assign tmo_hit   = en && (cnt >= tov);
  assign win_fault = feed_ok && en && (win != '0) && (cnt < win);
  assign fault_now = seq_fault || win_fault || tmo_hit;
  assign clr       = feed_ok || commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tripped <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (!tripped) begin
        if (fault_now) begin
          tripped <= 1'b1;
          rst_req <= 1'b1;
        end else if (clr) begin
          cnt <= '0;
        end else if (en) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R9
  hold_after_trip_chk: assert property (@(posedge clk) disable iff (rst)
    tripped |=> $stable(cnt));

  // R6
  feed_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (feed_ok && !tripped && !seq_fault && !tmo_hit && !win_fault) |=> (cnt == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/seq_wdog.sv
module seq_wdog
  import seq_wdog_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 16,
  parameter int UNLOCK_WIN = 128,
  parameter int TOV_RST    = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdog_rst_req
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_TOV  = ADDR_W'(OFS_TOV);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(OFS_WIN);

  logic cmd_we, other_we, ctrl_we, tov_we, win_we;
  assign cmd_we   = bus_we && (bus_addr == A_CMD);
  assign other_we = bus_we && (bus_addr != A_CMD);
  assign ctrl_we  = bus_we && (bus_addr == A_CTRL);
  assign tov_we   = bus_we && (bus_addr == A_TOV);
  assign win_we   = bus_we && (bus_addr == A_WIN);

  logic unlock_ok, feed_ok, seq_fault;
  logic en, upd, unlocked, cmt_flag, commit, tripped;
  logic [CNT_W-1:0] tov, win, cnt;

  seq_wdog_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (cmd_we),
    .other_we  (other_we),
    .wdata     (bus_wdata),
    .unlock_ok (unlock_ok),
    .feed_ok   (feed_ok),
    .seq_fault (seq_fault)
  );

  seq_wdog_cfg #(
    .CNT_W      (CNT_W),
    .UNLOCK_WIN (UNLOCK_WIN),
    .TOV_RST    (TOV_RST)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .tov_we     (tov_we),
    .win_we     (win_we),
    .wr_val     (bus_wdata[CNT_W-1:0]),
    .wr_en_bit  (bus_wdata[BIT_EN]),
    .wr_upd_bit (bus_wdata[BIT_UPD]),
    .unlock_ok  (unlock_ok),
    .en         (en),
    .upd        (upd),
    .unlocked   (unlocked),
    .cmt_flag   (cmt_flag),
    .tov        (tov),
    .win        (win),
    .commit     (commit)
  );

  seq_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tov       (tov),
    .win       (win),
    .feed_ok   (feed_ok),
    .commit    (commit),
    .seq_fault (seq_fault),
    .cnt       (cnt),
    .tripped   (tripped),
    .rst_req   (wdog_rst_req)
  );

  logic [DATA_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word          = '0;
    ctrl_word[BIT_EN]  = en;
    ctrl_word[BIT_UPD] = upd;
    ctrl_word[BIT_CMT] = cmt_flag;
    ctrl_word[BIT_ULK] = unlocked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_word;
        A_CMD:   bus_rdata <= DATA_W'(cnt);
        A_TOV:   bus_rdata <= DATA_W'(tov);
        A_WIN:   bus_rdata <= DATA_W'(win);
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R7
  bad_pair_req_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_fault && !tripped) |=> wdog_rst_req);

endmodule

// File: tb/seq_wdog_bench.sv
module seq_wdog_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        wdog_rst_req;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  seq_wdog u_seq_wdog (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .wdog_rst_req (wdog_rst_req)
  );

  always @(negedge clk) if (wdog_rst_req) pulses++;

  // op, addr, data, expected read value
  localparam logic [68:0] VEC [0:6] = '{
    {1'b1, 4'h8, 32'h0000_0200, 32'h0},
    {1'b0, 4'h8, 32'h0,         32'h0000_0200},
    {1'b1, 4'hC, 32'h0000_0010, 32'h0},
    {1'b0, 4'hC, 32'h0,         32'h0000_0010},
    {1'b0, 4'h0, 32'h0,         32'h0000_0080},
    {1'b1, 4'h0, 32'h0000_01A0, 32'h0},
    {1'b0, 4'h0, 32'h0,         32'h0000_04A0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_we = 1'b0;
    pulses = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    logic [68:0] e;
    @(negedge clk);

    // R1 reset state
    do_reset();
    rd(4'h0, v); chk("R1 ctrl", v, 32'h080);
    rd(4'h8, v); chk("R1 timeout", v, 32'h400);
    rd(4'hC, v); chk("R1 window", v, 32'h0);
    chk("R1 request", {31'b0, wdog_rst_req}, 32'h0);

    // R2 table walk: direct pre-commit writes, then commit
    do_reset();
    for (int i = 0; i < 7; i++) begin
      e = VEC[i];
      if (e[68]) wr(e[67:64], e[63:32]);
      else begin
        rd(e[67:64], v);
        chk($sformatf("R2 vec%0d", i), v, e[31:0]);
      end
    end

    // R9 counting and timeout
    do_reset();
    wr(4'h8, 32'd20);
    wr(4'h0, 32'h0A0);
    rd(4'h4, v); chk("R2 counter cleared by commit", v, 32'd0);
    rd(4'h4, v); chk("R9 counter step", v, 32'd1);
    repeat (25) @(negedge clk);
    chk("R9 one pulse", pulses, 1);
    rd(4'h4, v); chk("R9 counter held", v, 32'd20);
    repeat (10) @(negedge clk);
    rd(4'h4, v); chk("R9 still held", v, 32'd20);
    chk("R9 no second pulse", pulses, 1);

    // R9 feed one edge before timeout: accepted
    do_reset();
    wr(4'h8, 32'd20);
    wr(4'h0, 32'h0A0);
    repeat (18) @(negedge clk);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    rd(4'h4, v); chk("R6 feed before timeout", v, 32'd0);
    settle(); chk("R9 no pulse early feed", pulses, 0);

    // R9 feed on the timeout edge: request wins
    do_reset();
    wr(4'h8, 32'd20);
    wr(4'h0, 32'h0A0);
    repeat (19) @(negedge clk);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    rd(4'h4, v); chk("R9 coincident feed held", v, 32'd20);
    settle(); chk("R9 coincident pulse", pulses, 1);

    // R6 plain feed
    do_reset();
    repeat (30) @(negedge clk);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    rd(4'h4, v); chk("R6 feed clears", v, 32'd0);

    // R7 bad unlock second word
    do_reset();
    wr(4'h4, 32'hC520); wr(4'h4, 32'h1234);
    settle(); chk("R7 bad unlock pair", pulses, 1);
    // R7 bad feed second word
    do_reset();
    wr(4'h4, 32'hA602); wr(4'h4, 32'h0);
    settle(); chk("R7 bad feed pair", pulses, 1);

    // R8 window: counter 9 below window 10 -> fault
    do_reset();
    wr(4'hC, 32'd10);
    wr(4'h0, 32'h0A0);
    repeat (8) @(negedge clk);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    settle(); chk("R8 early feed", pulses, 1);
    // R8 counter equal to window -> accepted
    do_reset();
    wr(4'hC, 32'd10);
    wr(4'h0, 32'h0A0);
    repeat (9) @(negedge clk);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    rd(4'h4, v); chk("R8 boundary feed", v, 32'd0);
    settle(); chk("R8 boundary no pulse", pulses, 0);

    // R3 locked configuration
    do_reset();
    wr(4'h0, 32'h080);
    rd(4'h0, v); chk("R3 ctrl committed", v, 32'h480);
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    wr(4'h8, 32'h55);
    wr(4'h0, 32'h0);
    rd(4'h8, v); chk("R3 timeout frozen", v, 32'h400);
    rd(4'h0, v); chk("R3 ctrl frozen", v, 32'h480);

    // R10 disable with update permission
    do_reset();
    wr(4'h0, 32'h120);
    rd(4'h0, v); chk("R10 ctrl", v, 32'h420);
    rd(4'h4, v); rd(4'h4, v2);
    chk("R10 counter idle", v, 32'd0);
    chk("R10 counter idle again", v2, 32'd0);
    // R4 gating and unlock
    wr(4'h8, 32'h77);
    rd(4'h8, v); chk("R4 write without unlock", v, 32'h400);
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    rd(4'h0, v); chk("R4 unlocked status", v, 32'h820);
    wr(4'h8, 32'h77);
    rd(4'h8, v); chk("R4 timeout rewritten", v, 32'h77);
    wr(4'h0, 32'h120);
    rd(4'h0, v); chk("R4 recommit", v, 32'h420);
    // R5 lapse
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    repeat (140) @(negedge clk);
    rd(4'h0, v); chk("R5 unlock lapsed", v, 32'h020);
    wr(4'h8, 32'h99);
    rd(4'h8, v); chk("R5 write after lapse", v, 32'h77);
    // R5 inside the span
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    repeat (100) @(negedge clk);
    wr(4'hC, 32'd5);
    rd(4'hC, v); chk("R5 write inside span", v, 32'd5);
    settle(); chk("R10 no timeout while off", pulses, 0);

    // R11 stray word and broken pair
    do_reset();
    rd(4'h4, v);
    wr(4'h4, 32'h1234);
    rd(4'h4, v2); chk("R11 stray word", v2, v + 32'd2);
    rd(4'h4, v);
    wr(4'h4, 32'hA602); wr(4'h8, 32'h400); wr(4'h4, 32'hB480);
    rd(4'h4, v2); chk("R11 broken pair", v2, v + 32'd4);
    settle(); chk("R11 no pulse", pulses, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule